// File: doc/BRIEF.md
# Drawing Bounding Box Accumulator

This block sits beside a line-drawing engine and keeps a running rectangle around every pixel that the engine draws. Each time a pixel strobe arrives from the line-draw path, the block compares the pixel's signed X and Y against four stored extremes. It lowers the left or top extreme when the pixel lies beyond it, and it raises the right or bottom extreme in the same way. Software can read the rectangle afterwards to find out which region of the frame a drawing pass touched.

A clear request does not set the extremes to zero. It sets them to the opposite ends of the coordinate range: left and top go to the largest positive value, and right and bottom go to the most negative value. The first pixel drawn after a clear therefore sets all four extremes at once. Pixels from drawing sources other than the line-draw path are ignored. The extremes are also available on their own outputs. A read-select input picks one of them onto a single read-data word.

Top module: `bbox_accum`

## Requirements
- R1: The left bound holds the lowest X of all line-draw pixels accepted since the last clear.
- R2: The right bound holds the highest X of all line-draw pixels accepted since the last clear.
- R3: The top bound holds the lowest Y of all line-draw pixels accepted since the last clear.
- R4: The bottom bound holds the highest Y of all line-draw pixels accepted since the last clear.
- R5: A clear request, and also reset, sets left and top to +2047 (16'h07FF) and right and bottom to -2048 (16'hF800). The clear values are visible in the cycle after the clear.
- R6: If a clear request and a pixel strobe arrive in the same cycle, the clear takes effect and that pixel is not accumulated.
- R7: A pixel strobe with the line-draw source flag low leaves all four bounds unchanged.
- R8: Coordinates are 12-bit two's complement values and are compared as signed numbers, so a negative X or Y lowers the left or top bound.
- R9: Each bound is presented as a 16-bit word that is the sign extension of its 12-bit value.
- R10: The read-data output returns left for select 0, right for select 1, top for select 2 and bottom for select 3.
- R11: An accepted pixel changes the bounds at the clock edge that samples the strobe and not earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; released synchronously inside the block |
| pix_valid | input | 1 | Pixel strobe from the drawing engine |
| pix_is_line | input | 1 | High when the strobed pixel comes from the line-draw path |
| pix_x | input | COORD_W (12) | Signed pixel X |
| pix_y | input | COORD_W (12) | Signed pixel Y |
| clr_req | input | 1 | Resets all four bounds to their inverted extremes |
| rd_sel | input | 2 | Selects the bound shown on rd_data (0 left, 1 right, 2 top, 3 bottom) |
| bound_left | output | WORD_W (16) | Lowest X, sign-extended |
| bound_right | output | WORD_W (16) | Highest X, sign-extended |
| bound_top | output | WORD_W (16) | Lowest Y, sign-extended |
| bound_bottom | output | WORD_W (16) | Highest Y, sign-extended |
| rd_data | output | WORD_W (16) | Selected bound |

## Verification
The bench uses the default build, with COORD_W of 12 and WORD_W of 16. At that width both ends of the coordinate range, +2047 and -2048, can be driven directly. The bench uses them to test the inverted clear values, a pixel that sits exactly on a clear value, and the four sign bits added on readback. Because the words are only four bits wider than the coordinates, a wrong sign extension shows up as a wrong readback value in every vector that holds a negative bound.

// File: rtl/bbox_pkg.sv
package bbox_pkg;

  localparam int unsigned NUM_BOUNDS = 4;
  localparam int unsigned SEL_W      = 2;

  // Order of the bounds is the read-select encoding
  typedef enum logic [SEL_W-1:0] {
    SEL_LEFT   = 2'd0,
    SEL_RIGHT  = 2'd1,
    SEL_TOP    = 2'd2,
    SEL_BOTTOM = 2'd3
  } bound_sel_e;

  // A bound tracks a maximum (right, bottom) or a minimum (left, top)
  function automatic bit bound_is_max(input int unsigned idx);
    return (idx == SEL_RIGHT) || (idx == SEL_BOTTOM);
  endfunction

  // A bound follows Y (top, bottom) or X (left, right)
  function automatic bit bound_on_y(input int unsigned idx);
    return (idx == SEL_TOP) || (idx == SEL_BOTTOM);
  endfunction

endpackage

// File: rtl/bbox_rst_sync.sv
module bbox_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/bbox_extreme.sv
module bbox_extreme #(
  parameter int unsigned COORD_W = 12,
  parameter bit          IS_MAX  = 1'b0
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clr,
  input  logic                      upd,
  input  logic signed [COORD_W-1:0] sample,
  output logic signed [COORD_W-1:0] value
);

  localparam logic signed [COORD_W-1:0] TOP_VAL  = {1'b0, {(COORD_W-1){1'b1}}};
  localparam logic signed [COORD_W-1:0] BOT_VAL  = {1'b1, {(COORD_W-1){1'b0}}};
  localparam logic signed [COORD_W-1:0] INIT_VAL = IS_MAX ? BOT_VAL : TOP_VAL;

  logic signed [COORD_W-1:0] cur_q;
  logic signed [COORD_W-1:0] cur_d;
  logic                      beyond;
  logic                      en;

  always_comb begin
    if (IS_MAX) begin
      beyond = (sample > cur_q);
    end else begin
      beyond = (sample < cur_q);
    end
    en    = clr | (upd & beyond);
    cur_d = clr ? INIT_VAL : sample;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= INIT_VAL;
    end else if (en) begin
      cur_q <= cur_d;
    end
  end

  assign value = cur_q;

endmodule

// File: rtl/bbox_rd_mux.sv
module bbox_rd_mux
  import bbox_pkg::*;
#(
  parameter int unsigned WORD_W = 16
) (
  input  logic [NUM_BOUNDS-1:0][WORD_W-1:0] words,
  input  logic [SEL_W-1:0]                  sel,
  output logic [WORD_W-1:0]                 data
);

  always_comb begin
    data = words[sel];
  end

endmodule

// File: rtl/bbox_accum.sv
module bbox_accum
  import bbox_pkg::*;
#(
  parameter int unsigned COORD_W = 12,
  parameter int unsigned WORD_W  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pix_valid,
  input  logic               pix_is_line,
  input  logic [COORD_W-1:0] pix_x,
  input  logic [COORD_W-1:0] pix_y,
  input  logic               clr_req,
  input  logic [SEL_W-1:0]   rd_sel,
  output logic [WORD_W-1:0]  bound_left,
  output logic [WORD_W-1:0]  bound_right,
  output logic [WORD_W-1:0]  bound_top,
  output logic [WORD_W-1:0]  bound_bottom,
  output logic [WORD_W-1:0]  rd_data
);

  localparam int unsigned EXT_W = WORD_W - COORD_W;

  logic                                 rst_n_sync;
  logic                                 accept;
  logic [NUM_BOUNDS-1:0][COORD_W-1:0]   bnd_raw;
  logic [NUM_BOUNDS-1:0][WORD_W-1:0]    bnd_word;

  bbox_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  // Clear has priority; only line-draw pixels count
  assign accept = pix_valid & pix_is_line & ~clr_req;

  for (genvar gi = 0; gi < NUM_BOUNDS; gi++) begin : g_bound
    logic signed [COORD_W-1:0] smp;
    logic signed [COORD_W-1:0] val;

    assign smp = bound_on_y(gi) ? $signed(pix_y) : $signed(pix_x);

    bbox_extreme #(
      .COORD_W (COORD_W),
      .IS_MAX  (bound_is_max(gi))
    ) u_extreme (
      .clk    (clk),
      .rst_n  (rst_n_sync),
      .clr    (clr_req),
      .upd    (accept),
      .sample (smp),
      .value  (val)
    );

    assign bnd_raw[gi]  = val;
    assign bnd_word[gi] = {{EXT_W{val[COORD_W-1]}}, val};
  end

  bbox_rd_mux #(
    .WORD_W (WORD_W)
  ) u_rd_mux (
    .words (bnd_word),
    .sel   (rd_sel),
    .data  (rd_data)
  );

  assign bound_left   = bnd_word[SEL_LEFT];
  assign bound_right  = bnd_word[SEL_RIGHT];
  assign bound_top    = bnd_word[SEL_TOP];
  assign bound_bottom = bnd_word[SEL_BOTTOM];

endmodule

// File: rtl/bbox_accum_checker.sv
module bbox_accum_checker #(
  parameter int unsigned COORD_W = 12,
  parameter int unsigned WORD_W  = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               pix_valid,
  input logic               pix_is_line,
  input logic [COORD_W-1:0] pix_x,
  input logic [COORD_W-1:0] pix_y,
  input logic               clr_req,
  input logic [1:0]         rd_sel,
  input logic [WORD_W-1:0]  bound_left,
  input logic [WORD_W-1:0]  bound_right,
  input logic [WORD_W-1:0]  bound_top,
  input logic [WORD_W-1:0]  bound_bottom,
  input logic [WORD_W-1:0]  rd_data
);

  localparam int unsigned EXT_W = WORD_W - COORD_W;
  localparam logic [WORD_W-1:0] HI_W = {{(EXT_W+1){1'b0}}, {(COORD_W-1){1'b1}}};
  localparam logic [WORD_W-1:0] LO_W = {{(EXT_W+1){1'b1}}, {(COORD_W-1){1'b0}}};

  logic live;
  logic signed [WORD_W-1:0] xs;
  logic signed [WORD_W-1:0] ys;
  logic take;
  logic other;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live <= 1'b0;
    else        live <= 1'b1;
  end

  assign xs    = $signed({{EXT_W{pix_x[COORD_W-1]}}, pix_x});
  assign ys    = $signed({{EXT_W{pix_y[COORD_W-1]}}, pix_y});
  assign take  = pix_valid & pix_is_line & ~clr_req;
  assign other = pix_valid & ~pix_is_line & ~clr_req;

  AST_LEFT_BELOW_PIXEL: assert property (@(posedge clk) disable iff (!rst_n)
    live && $past(take) |-> $signed(bound_left) <= $past(xs)); // R1
  AST_RIGHT_ABOVE_PIXEL: assert property (@(posedge clk) disable iff (!rst_n)
    live && $past(take) |-> $signed(bound_right) >= $past(xs)); // R2
  AST_TOP_BELOW_PIXEL: assert property (@(posedge clk) disable iff (!rst_n)
    live && $past(take) |-> $signed(bound_top) <= $past(ys)); // R3
  AST_BOTTOM_ABOVE_PIXEL: assert property (@(posedge clk) disable iff (!rst_n)
    live && $past(take) |-> $signed(bound_bottom) >= $past(ys)); // R4
  AST_CLEAR_VALUES: assert property (@(posedge clk) disable iff (!rst_n)
    live && $past(clr_req) |-> bound_left == HI_W && bound_top == HI_W
      && bound_right == LO_W && bound_bottom == LO_W); // R5
  AST_CLEAR_BEATS_PIXEL: assert property (@(posedge clk) disable iff (!rst_n)
    live && $past(clr_req && pix_valid && pix_is_line) |-> bound_left == HI_W
      && bound_right == LO_W); // R6
  AST_OTHER_SOURCE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    live && $past(other) |-> $stable(bound_left) && $stable(bound_right)
      && $stable(bound_top) && $stable(bound_bottom)); // R7
  AST_LEFT_NEVER_RISES: assert property (@(posedge clk) disable iff (!rst_n)
    live && !$past(clr_req) |-> $signed(bound_left) <= $signed($past(bound_left))); // R8
  AST_READ_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
    rd_sel == 2'd0 |-> rd_data == bound_left); // R10
  AST_READ_BOTTOM: assert property (@(posedge clk) disable iff (!rst_n)
    rd_sel == 2'd3 |-> rd_data == bound_bottom); // R10
  AST_NO_SPURIOUS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    live && !$past(pix_valid) && !$past(clr_req) |-> $stable(bound_top)
      && $stable(bound_right)); // R11

endmodule

bind bbox_accum bbox_accum_checker #(
  .COORD_W (COORD_W),
  .WORD_W  (WORD_W)
) u_checker (
  .clk          (clk),
  .rst_n        (rst_n_sync),
  .pix_valid    (pix_valid),
  .pix_is_line  (pix_is_line),
  .pix_x        (pix_x),
  .pix_y        (pix_y),
  .clr_req      (clr_req),
  .rd_sel       (rd_sel),
  .bound_left   (bound_left),
  .bound_right  (bound_right),
  .bound_top    (bound_top),
  .bound_bottom (bound_bottom),
  .rd_data      (rd_data)
);

// File: tb/bbox_accum_bench.sv
module bbox_accum_bench;

  localparam int unsigned COORD_W = 12;
  localparam int unsigned WORD_W  = 16;
  localparam int unsigned NVEC    = 12;

  typedef struct packed {
    logic        clr;
    logic        vld;
    logic        line;
    logic [11:0] x;
    logic [11:0] y;
    logic [11:0] el;
    logic [11:0] er;
    logic [11:0] et;
    logic [11:0] eb;
  } vec_t;

  function automatic vec_t mk(input logic c, input logic v, input logic l,
                              input int x, input int y, input int el,
                              input int er, input int et, input int eb);
    vec_t r;
    r.clr = c; r.vld = v; r.line = l;
    r.x = x[11:0]; r.y = y[11:0];
    r.el = el[11:0]; r.er = er[11:0]; r.et = et[11:0]; r.eb = eb[11:0];
    return r;
  endfunction

  // clr vld line x y | expected left right top bottom
  localparam vec_t VEC [NVEC] = '{
    mk(0, 1, 1,    10,    20,    10,    10,    20,    20), // R1 R2 R3 R4 first point
    mk(0, 1, 1,     5,    30,     5,    10,    20,    30),
    mk(0, 1, 1,    -7,    -3,    -7,    10,    -3,    30), // R8 negatives
    mk(0, 1, 0,   100,    50,    -7,    10,    -3,    30), // R7 other source
    mk(0, 1, 1,   200,  -100,    -7,   200,  -100,    30),
    mk(1, 1, 1,     1,     1,  2047, -2048,  2047, -2048), // R6 clear beats pixel
    mk(0, 0, 1,   -50,   -50,  2047, -2048,  2047, -2048), // no strobe
    mk(0, 1, 1,  2047, -2048,  2047,  2047, -2048, -2048), // range ends
    mk(0, 1, 1, -2048,  2047, -2048,  2047, -2048,  2047),
    mk(1, 0, 0,     0,     0,  2047, -2048,  2047, -2048), // R5 clear
    mk(0, 1, 1,     0,     0,     0,     0,     0,     0),
    mk(0, 1, 1,     3,    -1,     0,     3,    -1,     0)
  };

  logic               clk;
  logic               rst_n;
  logic               pix_valid;
  logic               pix_is_line;
  logic [COORD_W-1:0] pix_x;
  logic [COORD_W-1:0] pix_y;
  logic               clr_req;
  logic [1:0]         rd_sel;
  logic [WORD_W-1:0]  bound_left;
  logic [WORD_W-1:0]  bound_right;
  logic [WORD_W-1:0]  bound_top;
  logic [WORD_W-1:0]  bound_bottom;
  logic [WORD_W-1:0]  rd_data;

  int  checks;
  int  failures;
  bit  done;

  bbox_accum #(.COORD_W(COORD_W), .WORD_W(WORD_W)) u_bbox_accum (
    .clk          (clk),
    .rst_n        (rst_n),
    .pix_valid    (pix_valid),
    .pix_is_line  (pix_is_line),
    .pix_x        (pix_x),
    .pix_y        (pix_y),
    .clr_req      (clr_req),
    .rd_sel       (rd_sel),
    .bound_left   (bound_left),
    .bound_right  (bound_right),
    .bound_top    (bound_top),
    .bound_bottom (bound_bottom),
    .rd_data      (rd_data)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk; // 50 MHz

  function automatic logic [15:0] sx(input logic [11:0] v);
    return {{4{v[11]}}, v};
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_all(input string req, input logic [11:0] l, input logic [11:0] r,
                         input logic [11:0] t, input logic [11:0] b);
    chk({req, " left"},   bound_left,   sx(l));
    chk({req, " right"},  bound_right,  sx(r));
    chk({req, " top"},    bound_top,    sx(t));
    chk({req, " bottom"}, bound_bottom, sx(b));
  endtask

  task automatic drive(input logic c, input logic v, input logic l,
                       input logic [11:0] x, input logic [11:0] y);
    clr_req = c; pix_valid = v; pix_is_line = l; pix_x = x; pix_y = y;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    checks = 0; failures = 0; done = 1'b0;
    rst_n = 1'b0; rd_sel = 2'd0;
    drive(0, 0, 0, 12'd0, 12'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R5: reset state equals the clear values
    chk_all("R5 reset", 12'sd2047, -12'sd2048, 12'sd2047, -12'sd2048);

    // Table walk: drive at negedge, check at the following negedge
    for (int i = 0; i < NVEC; i++) begin
      drive(VEC[i].clr, VEC[i].vld, VEC[i].line, VEC[i].x, VEC[i].y);
      @(negedge clk);
      chk_all($sformatf("R1-4 vec%0d", i), VEC[i].el, VEC[i].er, VEC[i].et, VEC[i].eb);
    end
    drive(0, 0, 0, 12'd0, 12'd0);

    // R10 and R9: read select order, sign extension of top = -1
    for (int s = 0; s < 4; s++) begin
      rd_sel = s[1:0];
      #1;
      case (s)
        0: chk("R10 sel left",   rd_data, 16'h0000);
        1: chk("R10 sel right",  rd_data, 16'h0003);
        2: chk("R9 R10 sel top", rd_data, 16'hFFFF);
        default: chk("R10 sel bottom", rd_data, 16'h0000);
      endcase
    end

    // R11: a pixel is not visible before the sampling edge
    drive(0, 1, 1, 12'd500, 12'd600);
    #2;
    chk("R11 before edge right", bound_right, 16'h0003);
    @(negedge clk);
    chk("R11 after edge right", bound_right, 16'd500);
    chk("R4 after edge bottom", bound_bottom, 16'd600);
    drive(0, 0, 0, 12'd0, 12'd0);

    // R7: a non-line pixel with extreme coordinates leaves every bound alone
    drive(0, 1, 0, 12'h800, 12'h7FF);
    @(negedge clk);
    chk_all("R7 ignored", 12'd0, 12'd500, -12'sd1, 12'd600);
    drive(0, 0, 0, 12'd0, 12'd0);

    // R9: most negative value reads back as 16'hF800
    drive(0, 1, 1, 12'h800, 12'h000);
    @(negedge clk);
    rd_sel = 2'd0;
    #1;
    chk("R9 left readback", rd_data, 16'hF800);
    drive(0, 0, 0, 12'd0, 12'd0);

    // R5: asynchronous reset mid-run restores the clear values
    rst_n = 1'b0;
    #3;
    chk_all("R5 async reset", 12'sd2047, -12'sd2048, 12'sd2047, -12'sd2048);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk_all("R5 after reset", 12'sd2047, -12'sd2048, 12'sd2047, -12'sd2048);

    finish_run();
  end

endmodule